// File: doc/BRIEF.md
# Modem Status Register with Change Tracking

This block watches four active-low handshake lines coming from a modem or similar peripheral: clear to send, data set ready, ring indicator and carrier detect. Each line is brought into the clock domain through a short synchronizer. The block then offers one 8-bit word that the CPU can read. The upper nibble carries the present level of each line, inverted so that an asserted (low) line reads as 1. The lower nibble holds sticky change flags that record activity since the previous read.

A read is a single-cycle strobe. While the strobe is high the data port shows the current word, and the change flags clear at the end of that cycle. The ring flag reacts only when ring ends (pin going back high); the other three flags react to a change in either direction. A change that arrives in the same cycle as a read is never lost: it is seen on the next read. An interrupt request is raised while the modem-status interrupt enable is set and any change flag is 1.

Top module: `msr_top`

## Requirements
- R1: Read data bits 4, 5, 6 and 7 show clear to send, data set ready, ring indicator and carrier detect respectively; a bit is 1 when its pin is low and 0 when its pin is high.
- R2: Bit 0 (clear to send), bit 1 (data set ready) and bit 3 (carrier detect) become 1 after the pin changes in either direction; several changes before a read still give a single 1.
- R3: Bit 2 becomes 1 only when the ring pin goes from low to high; a high-to-low change on the ring pin leaves bit 2 at 0.
- R4: Change flags stay at 1 until a read. A read returns the flags as they stand and they read 0 afterwards unless a new change arrived.
- R5: When a flag sets in the same cycle as a read, that read returns the earlier flag value and the flag reads 1 on the following read.
- R6: irq is 1 while irq_en is 1 and any change flag is 1; it is 0 when irq_en is 0 and it drops after a read clears the flags.
- R7: After reset all change flags are 0 and irq is 0, the status bits follow the pin levels present during reset, and reset causes no change flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset, at least two cycles |
| cts_n | input | 1 | Clear to send, active low, asynchronous |
| dsr_n | input | 1 | Data set ready, active low, asynchronous |
| ri_n | input | 1 | Ring indicator, active low, asynchronous |
| dcd_n | input | 1 | Carrier detect, active low, asynchronous |
| rd_en | input | 1 | One-cycle read strobe; clears the change flags at the end of the cycle |
| rd_data | output | 8 | Status nibble in bits 7:4, change flags in bits 3:0 |
| irq_en | input | 1 | Modem-status interrupt enable |
| irq | output | 1 | Modem-status interrupt request |

## Verification
The bench goes after the ring line in both directions. A design that treated ring like the other lines would flag the start of ring as well as its end. It toggles a line twice between reads; a design that toggled the flag instead of setting it would report no change. It lines up a pin change so that the flag sets in the very cycle the read strobe is high; a design that let the clear win would silently lose that change. It also starts from reset with carrier detect already low, which exposes a design that clears the status or raises a false flag on reset, and it checks that irq follows the enable and drops after the clearing read.

// File: rtl/msr_pkg.sv
package msr_pkg;

    localparam int LINES     = 4;
    localparam int IDX_CTS   = 0;
    localparam int IDX_DSR   = 1;
    localparam int IDX_RI    = 2;
    localparam int IDX_DCD   = 3;
    localparam int WORD_W    = 2 * LINES;

    typedef enum logic [0:0] {
        DET_ANY      = 1'b0,
        DET_PIN_RISE = 1'b1
    } det_e;

    typedef struct packed {
        logic [LINES-1:0] level;
        logic [LINES-1:0] delta;
    } msr_word_t;

    function automatic det_e line_mode(input int idx);
        return (idx == IDX_RI) ? DET_PIN_RISE : DET_ANY;
    endfunction

    // cur/prev are synchronized pin levels (1 = high)
    function automatic logic edge_hit(input det_e mode, input logic cur, input logic prev);
        logic hit;
        case (mode)
            DET_PIN_RISE: hit = cur & ~prev;
            default:      hit = cur ^ prev;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/msr_sync.sv
module msr_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    localparam int LAST = STAGES - 1;

    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int k = 0; k < STAGES; k++) stg[k] <= din;
        end else begin
            stg[0] <= din;
            for (int k = 1; k < STAGES; k++) stg[k] <= stg[k-1];
        end
    end

    assign dout = stg[LAST];

endmodule

// File: rtl/msr_delta.sv
module msr_delta
    import msr_pkg::*;
#(
    parameter int WIDTH = LINES
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] pins_s,
    input  logic             rd_en,
    output logic [WIDTH-1:0] delta
);
    logic [WIDTH-1:0] prev;
    logic [WIDTH-1:0] set_vec;

    for (genvar i = 0; i < WIDTH; i++) begin : g_det
        assign set_vec[i] = edge_hit(line_mode(i), pins_s[i], prev[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev  <= pins_s;
            delta <= '0;
        end else begin
            prev  <= pins_s;
            delta <= (rd_en ? '0 : delta) | set_vec;
        end
    end

    // R4
    delta_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> ((delta & $past(delta)) == $past(delta)));

    // R5
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> ((delta & ~$past(set_vec)) == '0));

    // R3
    ri_fall_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!rd_en && !delta[IDX_RI] && !pins_s[IDX_RI] && prev[IDX_RI]) |=> !delta[IDX_RI]);

    // R7
    reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (delta == '0));

endmodule

// File: rtl/msr_top.sv
module msr_top
    import msr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cts_n,
    input  logic              dsr_n,
    input  logic              ri_n,
    input  logic              dcd_n,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    input  logic              irq_en,
    output logic              irq
);
    logic [LINES-1:0] pins_raw;
    logic [LINES-1:0] pins_s;
    logic [LINES-1:0] delta;
    msr_word_t        word;

    assign pins_raw[IDX_CTS] = cts_n;
    assign pins_raw[IDX_DSR] = dsr_n;
    assign pins_raw[IDX_RI]  = ri_n;
    assign pins_raw[IDX_DCD] = dcd_n;

    msr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst  (rst),
        .din  (pins_raw),
        .dout (pins_s)
    );

    msr_delta #(.WIDTH(LINES)) delta_i (
        .clk    (clk),
        .rst    (rst),
        .pins_s (pins_s),
        .rd_en  (rd_en),
        .delta  (delta)
    );

    always_comb begin
        word.level = ~pins_s;
        word.delta = delta;
    end

    assign rd_data = word;
    assign irq     = irq_en & (|word.delta);

    // R6
    irq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_en && $rose(|delta)) |-> irq);

    // R6
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

// File: tb/msr_top_tb_top.sv
module msr_top_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cts_n = 1'b1, dsr_n = 1'b1, ri_n = 1'b1, dcd_n = 1'b0;
    logic       rd_en = 1'b0;
    logic       irq_en = 1'b0;
    logic [7:0] rd_data;
    logic       irq;

    int checks = 0;
    int errors = 0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    msr_top dut_i (
        .clk(clk), .rst(rst),
        .cts_n(cts_n), .dsr_n(dsr_n), .ri_n(ri_n), .dcd_n(dcd_n),
        .rd_en(rd_en), .rd_data(rd_data),
        .irq_en(irq_en), .irq(irq)
    );

    task automatic finish_run();
        if (exp_q.size() != 0) begin
            checks++; errors++;
            $display("FAIL scoreboard: %0d reads not observed, expected 0", exp_q.size());
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // driver: push expected word, then strobe one read cycle
    task automatic do_read(input logic [7:0] exp, input string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(posedge clk); #1 rd_en = 1'b1;
        @(posedge clk); #1 rd_en = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int k = 0; k < n; k++) @(posedge clk);
        #1;
    endtask

    task automatic check_irq(input logic exp, input string tag);
        @(negedge clk);
        checks++;
        if (irq !== exp) begin
            errors++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, exp);
        end
    endtask

    // monitor: compare each read against the scoreboard
    always @(negedge clk) begin
        if (rd_en) begin
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL scoreboard: unexpected read actual %02h expected none", rd_data);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: rd_data actual %02h expected %02h", t, rd_data, e);
                end
            end
        end
    end

    initial begin
        #(200000 * 4);
        checks++; errors++;
        $display("FAIL watchdog: run hung, actual timeout expected completion");
        finish_run();
    end

    initial begin
        wait_cycles(5);
        rst = 1'b0;
        wait_cycles(4);
        // R7: carrier low during reset, no flags
        check_irq(1'b0, "R7 irq after reset");
        do_read(8'h80, "R7 status after reset");

        // R1, R2: cts falls
        cts_n = 1'b0;
        wait_cycles(5);
        check_irq(1'b0, "R6 irq masked");
        do_read(8'h91, "R1 R2 cts low");
        do_read(8'h90, "R4 cleared after read");

        // R2: cts rises
        cts_n = 1'b1;
        wait_cycles(5);
        do_read(8'h81, "R2 cts high");
        do_read(8'h80, "R4 cleared again");

        // R3: ring starts, then ends
        ri_n = 1'b0;
        wait_cycles(5);
        do_read(8'hC0, "R3 ring start ignored");
        ri_n = 1'b1;
        wait_cycles(5);
        do_read(8'h84, "R3 ring end flagged");
        do_read(8'h80, "R4 ring flag cleared");

        // R2: double toggle of dsr before a read
        dsr_n = 1'b0;
        wait_cycles(5);
        dsr_n = 1'b1;
        wait_cycles(5);
        do_read(8'h82, "R2 dsr double change");

        // R2: carrier goes high
        dcd_n = 1'b1;
        wait_cycles(5);
        do_read(8'h08, "R2 dcd change");

        // R4, R6: sticky flag and interrupt
        irq_en = 1'b1;
        cts_n = 1'b0;
        wait_cycles(20);
        check_irq(1'b1, "R6 irq asserted");
        irq_en = 1'b0;
        check_irq(1'b0, "R6 irq disabled");
        irq_en = 1'b1;
        check_irq(1'b1, "R6 irq re-enabled");
        do_read(8'h11, "R4 sticky flag");
        check_irq(1'b0, "R6 irq dropped after read");

        // R5: flag sets in the read cycle
        @(posedge clk); #1 cts_n = 1'b1;
        @(posedge clk);
        do_read(8'h00, "R5 read returns old flags");
        check_irq(1'b1, "R6 irq from same-cycle change");
        do_read(8'h01, "R5 change kept");
        check_irq(1'b0, "R6 irq low at end");

        wait_cycles(3);
        finish_run();
    end

endmodule